// File: doc/BRIEF.md
# Bus Watch Comparator Bank

This block watches every bus cycle that a processor issues and raises one match flag per comparator, which a downstream trigger sequencer consumes. The bank holds four comparators. The two even comparators (index 0 and 2) check the address together with a 16-bit data value, where each data bit can be masked out. The two odd comparators (index 1 and 3) check the address only, and they can be limited to byte or to word accesses. Each comparator can be set to fire on read cycles or on write cycles, and each has its own enable.

A bank-wide mode register sets how comparators 0 and 1 work. The mode register is a small state machine with three states. In PLAIN, every comparator checks for an exact address match on its own. In INSIDE, comparators 0 and 1 form one range check, where comparator 0 holds the lower bound and comparator 1 holds the upper bound. In OUTSIDE, the same pair fires when the address falls outside those bounds. A mode write moves the machine to the state selected by the written code, from any state, and code 3 goes to PLAIN. Comparators 2 and 3 always work in plain fashion. All settings are loaded through a single-cycle register write port. Each match flag is registered and stays high for exactly one cycle for each qualifying bus cycle.

Top module: `buswatch_bank`

## Requirements
- R1: After reset, all four match outputs are 0, every comparator is disabled, and the mode is PLAIN.
- R2: A write with `cfg_we`=1 takes effect from the next clock cycle. `cfg_addr[4]`=1 selects the mode register. Otherwise `cfg_addr[3:2]` selects the comparator and `cfg_addr[1:0]` selects the field: 0 = control, 1 = address, 2 = data value, 3 = data mask. The control bits are: bit0 enable, bit1 direction, bit2 size-check enable, bit3 size select.
- R3: A comparator whose enable bit is 0 never drives its match output to 1.
- R4: Direction bit 1 matches only write cycles (`bus_write`=1). Direction bit 0 matches only read cycles.
- R5: Comparators 0 and 2 match only when `bus_data` equals the stored data on every bit whose mask bit is 1. Bits whose mask bit is 0 are ignored.
- R6: Comparators 1 and 3 with size-check enable = 1 match only when `bus_word` equals the size select bit (1 = word, 0 = byte). With size-check enable = 0, either size matches.
- R7: In PLAIN mode, each enabled comparator matches when `bus_valid`=1, the address is equal to its stored address, and all of its other qualifiers hold.
- R8: In INSIDE mode (mode code 1), `match_o[0]` fires when addr0 ≤ address ≤ addr1 and the non-address qualifiers of both comparator 0 and comparator 1 hold. `match_o[1]` stays 0.
- R9: In OUTSIDE mode (mode code 2), `match_o[0]` fires when the address is below addr0 or above addr1 and both comparators' non-address qualifiers hold. `match_o[1]` stays 0.
- R10: The mode setting has no effect on comparators 2 and 3.
- R11: Each match output rises in the cycle after the qualifying bus cycle and lasts one cycle. Back-to-back qualifying cycles give consecutive high cycles. An idle cycle (`bus_valid`=0) gives all zeros.
- R12: Writing mode code 3 selects PLAIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register select (mode flag, comparator index, field) |
| cfg_wdata | input | CFG_W (32) | Register write value |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_data | input | DATA_W (16) | Bus data |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| match_o | output | 4 | Registered per-comparator match flags |

## Verification
The hardest case to reach from the ports is an exact 16-bit address hit that must also pass the data mask, the direction and the size qualifiers. The range edges addr0 and addr1 are hard in the same way, because a check there must tell ≤ from <. Random stimulus almost never lands on these values by chance. The random phase therefore takes most addresses from the currently programmed values and from their neighbours at ±1. It also mixes in random reprogramming of every field and of the mode, and directed sequences pin each range boundary exactly.

// File: rtl/buswatch_pkg.sv
package buswatch_pkg;

    localparam int NUM_CMP = 4;
    localparam int CMP_IW  = $clog2(NUM_CMP);
    localparam int CFG_AW  = CMP_IW + 3;

    localparam logic [1:0] FLD_CTRL = 2'd0;
    localparam logic [1:0] FLD_ADDR = 2'd1;
    localparam logic [1:0] FLD_DATA = 2'd2;
    localparam logic [1:0] FLD_MASK = 2'd3;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_INSIDE  = 2'd1,
        MODE_OUTSIDE = 2'd2
    } bw_mode_e;

    typedef struct packed {
        logic en;
        logic wr;
        logic sz_en;
        logic sz_word;
    } bw_ctrl_t;

endpackage

// File: rtl/bw_cfg_regs.sv
module bw_cfg_regs
    import buswatch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [CFG_AW-1:0]                   cfg_addr,
    input  logic [CFG_W-1:0]                    cfg_wdata,
    output bw_ctrl_t [NUM_CMP-1:0]              ctrl_o,
    output logic [NUM_CMP-1:0][ADDR_W-1:0]      addr_o,
    output logic [NUM_CMP-1:0][DATA_W-1:0]      data_o,
    output logic [NUM_CMP-1:0][DATA_W-1:0]      mask_o,
    output bw_mode_e                            mode_o
);

    logic              mode_wr;
    logic              field_wr;
    logic [CMP_IW-1:0] sel_idx;
    logic [1:0]        sel_fld;
    bw_mode_e          mode_q;
    bw_mode_e          mode_d;
    logic              unused_wdata;

    assign mode_wr      = cfg_we &&  cfg_addr[CFG_AW-1];
    assign field_wr     = cfg_we && !cfg_addr[CFG_AW-1];
    assign sel_idx      = cfg_addr[2 +: CMP_IW];
    assign sel_fld      = cfg_addr[1:0];
    assign unused_wdata = ^cfg_wdata;

    // Mode state machine: next-state process
    always_comb begin
        mode_d = mode_q;
        if (mode_wr) begin
            unique case (cfg_wdata[1:0])
                2'd1:    mode_d = MODE_INSIDE;
                2'd2:    mode_d = MODE_OUTSIDE;
                default: mode_d = MODE_PLAIN;
            endcase
        end
    end

    // Mode state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_PLAIN;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;

    // Per-comparator field registers
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
        logic     slot_wr;
        bw_ctrl_t ctrl_q;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] data_q;
        logic [DATA_W-1:0] mask_q;

        assign slot_wr = field_wr && (sel_idx == CMP_IW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q <= '0;
                addr_q <= '0;
                data_q <= '0;
                mask_q <= '0;
            end else if (slot_wr) begin
                unique case (sel_fld)
                    FLD_CTRL: begin
                        ctrl_q.en      <= cfg_wdata[0];
                        ctrl_q.wr      <= cfg_wdata[1];
                        ctrl_q.sz_en   <= cfg_wdata[2];
                        ctrl_q.sz_word <= cfg_wdata[3];
                    end
                    FLD_ADDR: addr_q <= cfg_wdata[ADDR_W-1:0];
                    FLD_DATA: data_q <= cfg_wdata[DATA_W-1:0];
                    FLD_MASK: mask_q <= cfg_wdata[DATA_W-1:0];
                    default:  ;
                endcase
            end
        end

        assign ctrl_o[i] = ctrl_q;
        assign addr_o[i] = addr_q;
        assign data_o[i] = data_q;
        assign mask_o[i] = mask_q;
    end

    p_mode_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_wr) && ($past(mode_q) == MODE_PLAIN) |-> mode_q == MODE_PLAIN);

    p_mode_code3_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && (cfg_wdata[1:0] == 2'd3) |=> mode_q == MODE_PLAIN);

endmodule

// File: rtl/bw_cmp_unit.sv
module bw_cmp_unit
    import buswatch_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter bit HAS_DATA = 1'b1
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_write,
    input  logic              bus_word,
    input  bw_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] ref_mask,
    output logic              qual_o,
    output logic              addr_eq_o
);

    logic dir_ok;
    logic extra_ok;

    assign dir_ok = (bus_write == ctrl.wr);

    if (HAS_DATA) begin : g_data
        logic unused_size;
        assign unused_size = ctrl.sz_en ^ ctrl.sz_word ^ bus_word;
        assign extra_ok    = (((bus_data ^ ref_data) & ref_mask) == '0);
    end else begin : g_size
        logic unused_data;
        assign unused_data = ^{bus_data, ref_data, ref_mask};
        assign extra_ok    = !ctrl.sz_en || (bus_word == ctrl.sz_word);
    end

    assign qual_o    = bus_valid && ctrl.en && dir_ok && extra_ok;
    assign addr_eq_o = (bus_addr == ref_addr);

endmodule

// File: rtl/bw_range_unit.sv
module bw_range_unit
    import buswatch_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  bw_mode_e          mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic              qual_lo,
    input  logic              qual_hi,
    input  logic              eq_lo,
    input  logic              eq_hi,
    output logic              hit_lo,
    output logic              hit_hi
);

    logic above_lo;
    logic below_hi;
    logic pair_ok;

    assign above_lo = (bus_addr >= lo_addr);
    assign below_hi = (bus_addr <= hi_addr);
    assign pair_ok  = qual_lo && qual_hi;

    always_comb begin
        unique case (mode)
            MODE_PLAIN: begin
                hit_lo = qual_lo && eq_lo;
                hit_hi = qual_hi && eq_hi;
            end
            MODE_INSIDE: begin
                hit_lo = pair_ok && above_lo && below_hi;
                hit_hi = 1'b0;
            end
            MODE_OUTSIDE: begin
                hit_lo = pair_ok && (!above_lo || !below_hi);
                hit_hi = 1'b0;
            end
            default: begin
                hit_lo = 1'b0;
                hit_hi = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/buswatch_bank.sv
module buswatch_bank
    import buswatch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               bus_write,
    input  logic               bus_word,
    output logic [NUM_CMP-1:0] match_o
);

    bw_ctrl_t [NUM_CMP-1:0]         ctrl;
    logic [NUM_CMP-1:0][ADDR_W-1:0] ref_addr;
    logic [NUM_CMP-1:0][DATA_W-1:0] ref_data;
    logic [NUM_CMP-1:0][DATA_W-1:0] ref_mask;
    bw_mode_e                       mode;
    logic [NUM_CMP-1:0]             qual;
    logic [NUM_CMP-1:0]             addr_eq;
    logic [NUM_CMP-1:0]             hit_d;
    logic [NUM_CMP-1:0]             match_q;

    bw_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CFG_W  (CFG_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl_o    (ctrl),
        .addr_o    (ref_addr),
        .data_o    (ref_data),
        .mask_o    (ref_mask),
        .mode_o    (mode)
    );

    // Even slots compare data, odd slots qualify on access size
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        bw_cmp_unit #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .HAS_DATA ((i % 2) == 0)
        ) u_unit (
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .bus_write (bus_write),
            .bus_word  (bus_word),
            .ctrl      (ctrl[i]),
            .ref_addr  (ref_addr[i]),
            .ref_data  (ref_data[i]),
            .ref_mask  (ref_mask[i]),
            .qual_o    (qual[i]),
            .addr_eq_o (addr_eq[i])
        );
    end

    // Slots 0/1 may pair into a range check
    bw_range_unit #(
        .ADDR_W (ADDR_W)
    ) u_range (
        .mode     (mode),
        .bus_addr (bus_addr),
        .lo_addr  (ref_addr[0]),
        .hi_addr  (ref_addr[1]),
        .qual_lo  (qual[0]),
        .qual_hi  (qual[1]),
        .eq_lo    (addr_eq[0]),
        .eq_hi    (addr_eq[1]),
        .hit_lo   (hit_d[0]),
        .hit_hi   (hit_d[1])
    );

    // Remaining slots always work as plain comparators
    for (genvar j = 2; j < NUM_CMP; j++) begin : g_plain
        assign hit_d[j] = qual[j] && addr_eq[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
        end else begin
            match_q <= hit_d;
        end
    end

    assign match_o = match_q;

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_chk
        p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[k].en |=> !match_o[k]);
    end

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> match_o == '0);

    p_dir_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && (bus_write != ctrl[2].wr) |=> !match_o[2]);

    p_size_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[3].sz_en && (bus_word != ctrl[3].sz_word) |=> !match_o[3]);

    p_pair_hi_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_PLAIN) |=> !match_o[1]);

    p_inside_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INSIDE) && (bus_addr < ref_addr[0]) |=> !match_o[0]);

    p_outside_within_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OUTSIDE) && (bus_addr >= ref_addr[0]) && (bus_addr <= ref_addr[1])
        |=> !match_o[0]);

endmodule

// File: tb/tb_buswatch_bank.sv
module tb_buswatch_bank;

    localparam int AW = 16;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic        bus_write = 1'b0;
    logic        bus_word = 1'b0;
    logic [3:0]  match_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]    m_ctrl [4];
    logic [AW-1:0] m_addr [4];
    logic [DW-1:0] m_data [4];
    logic [DW-1:0] m_mask [4];
    logic [1:0]    m_mode;

    always #5 clk = ~clk;

    buswatch_bank dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .bus_valid (bus_valid), .bus_addr (bus_addr),
        .bus_data (bus_data), .bus_write (bus_write), .bus_word (bus_word),
        .match_o (match_o)
    );

    function automatic logic [3:0] model(logic v, logic [AW-1:0] a, logic [DW-1:0] d,
                                         logic w, logic wd);
        logic [3:0] q;
        logic [3:0] e;
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            q[i] = v && m_ctrl[i][0] && (w == m_ctrl[i][1]) &&
                   (((i % 2) == 0) ? (((d ^ m_data[i]) & m_mask[i]) == '0)
                                   : (!m_ctrl[i][2] || (wd == m_ctrl[i][3])));
            e[i] = (a == m_addr[i]);
            r[i] = q[i] && e[i];
        end
        if (m_mode == 2'd1) begin
            r[0] = q[0] && q[1] && (a >= m_addr[0]) && (a <= m_addr[1]);
            r[1] = 1'b0;
        end else if (m_mode == 2'd2) begin
            r[0] = q[0] && q[1] && ((a < m_addr[0]) || (a > m_addr[1]));
            r[1] = 1'b0;
        end
        return r;
    endfunction

    task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: match_o=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] v);
        bus_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (a[4]) begin
            m_mode = v[1:0];
        end else begin
            case (a[1:0])
                2'd0: m_ctrl[a[3:2]] = v[3:0];
                2'd1: m_addr[a[3:2]] = v[AW-1:0];
                2'd2: m_data[a[3:2]] = v[DW-1:0];
                default: m_mask[a[3:2]] = v[DW-1:0];
            endcase
        end
    endtask

    task automatic bus_chk(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic w, input logic wd, input logic [3:0] exp,
                           input string tag);
        bus_valid = v;
        bus_addr  = a;
        bus_data  = d;
        bus_write = w;
        bus_word  = wd;
        @(posedge clk);
        #1;
        check(match_o, exp, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ctrl[i] = '0; m_addr[i] = '0; m_data[i] = '0; m_mask[i] = '0;
        end
        m_mode = 2'd0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state, and reset config matches nothing even at address 0
        check(match_o, 4'b0000, "R1 reset outputs");
        bus_chk(1, 16'h0000, 16'h0000, 0, 0, 4'b0000, "R1 disabled after reset");
        bus_chk(1, 16'h0000, 16'h0000, 1, 1, 4'b0000, "R3 disabled never matches");

        // Comparator 0: read, address 0x1000, data 0x12xx
        cfg_write(5'h01, 32'h0000_1000);
        cfg_write(5'h02, 32'h0000_12AB);
        cfg_write(5'h03, 32'h0000_FF00);
        cfg_write(5'h00, 32'h0000_0001);
        bus_chk(1, 16'h1000, 16'h12CD, 0, 0, 4'b0001, "R2 write takes effect next cycle");
        bus_chk(1, 16'h1000, 16'h13CD, 0, 0, 4'b0000, "R5 masked data mismatch");
        bus_chk(1, 16'h1000, 16'h1200, 0, 1, 4'b0001, "R5 unmasked bits ignored");
        bus_chk(1, 16'h1000, 16'h12CD, 1, 0, 4'b0000, "R4 write cycle vs read setting");
        bus_chk(1, 16'h1001, 16'h12CD, 0, 0, 4'b0000, "R7 address off by one");

        // Comparator 1: write, size check, word
        cfg_write(5'h05, 32'h0000_2000);
        cfg_write(5'h04, 32'h0000_000F);
        bus_chk(1, 16'h2000, 16'h0000, 1, 1, 4'b0010, "R6 word access accepted");
        bus_chk(1, 16'h2000, 16'h0000, 1, 0, 4'b0000, "R6 byte access rejected");
        bus_chk(1, 16'h2000, 16'h0000, 0, 1, 4'b0000, "R4 read vs write setting");
        cfg_write(5'h04, 32'h0000_0003);
        bus_chk(1, 16'h2000, 16'h0000, 1, 0, 4'b0010, "R6 size check off");

        // R11: back-to-back hits, then idle
        bus_chk(1, 16'h2000, 16'h0000, 1, 1, 4'b0010, "R11 first of pair");
        bus_chk(1, 16'h2000, 16'h0000, 1, 1, 4'b0010, "R11 second of pair");
        bus_chk(0, 16'h2000, 16'h0000, 1, 1, 4'b0000, "R11 idle clears");

        // Inside range 0x100..0x1FF
        cfg_write(5'h01, 32'h0000_0100);
        cfg_write(5'h03, 32'h0000_0000);
        cfg_write(5'h05, 32'h0000_01FF);
        cfg_write(5'h04, 32'h0000_0001);
        cfg_write(5'h10, 32'h0000_0001);
        bus_chk(1, 16'h00FF, 16'h0000, 0, 0, 4'b0000, "R8 below lower bound");
        bus_chk(1, 16'h0100, 16'h0000, 0, 0, 4'b0001, "R8 at lower bound");
        bus_chk(1, 16'h01FF, 16'h0000, 0, 0, 4'b0001, "R8 at upper bound");
        bus_chk(1, 16'h0200, 16'h0000, 0, 0, 4'b0000, "R8 above upper bound");
        cfg_write(5'h04, 32'h0000_0000);
        bus_chk(1, 16'h0150, 16'h0000, 0, 0, 4'b0000, "R8 needs both enabled");
        cfg_write(5'h04, 32'h0000_0001);
        bus_chk(1, 16'h0150, 16'h0000, 0, 0, 4'b0001, "R8 mid range");

        // Outside range
        cfg_write(5'h10, 32'h0000_0002);
        bus_chk(1, 16'h00FF, 16'h0000, 0, 0, 4'b0001, "R9 below lower bound");
        bus_chk(1, 16'h0100, 16'h0000, 0, 0, 4'b0000, "R9 at lower bound");
        bus_chk(1, 16'h01FF, 16'h0000, 0, 0, 4'b0000, "R9 at upper bound");
        bus_chk(1, 16'h0200, 16'h0000, 0, 0, 4'b0001, "R9 above upper bound");
        bus_chk(1, 16'h0200, 16'h0000, 1, 0, 4'b0000, "R9 direction still applies");

        // R10: comparator 2 unaffected by range mode
        cfg_write(5'h09, 32'h0000_0150);
        cfg_write(5'h0B, 32'h0000_0000);
        cfg_write(5'h08, 32'h0000_0001);
        bus_chk(1, 16'h0150, 16'h0000, 0, 0, 4'b0100, "R10 slot 2 plain in outside mode");
        bus_chk(1, 16'h0050, 16'h0000, 0, 0, 4'b0001, "R10 range only");

        // R12: code 3 is plain
        cfg_write(5'h10, 32'h0000_0003);
        bus_chk(1, 16'h0100, 16'h0000, 0, 0, 4'b0001, "R12 code 3 plain slot 0");
        bus_chk(1, 16'h01FF, 16'h0000, 0, 0, 4'b0010, "R12 code 3 plain slot 1");

        // Constrained random phase
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 8) == 0) begin
                logic [4:0] ra;
                ra = 5'($urandom % 17);
                cfg_write(ra, $urandom);
            end else begin
                logic [AW-1:0] a;
                logic [DW-1:0] d;
                logic v;
                logic w;
                logic wd;
                int pick;
                pick = int'($urandom % 4);
                case ($urandom % 4)
                    0: a = m_addr[pick];
                    1: a = m_addr[pick] + 16'd1;
                    2: a = m_addr[pick] - 16'd1;
                    default: a = 16'($urandom);
                endcase
                d  = ($urandom % 2 == 0) ? m_data[pick] : 16'($urandom);
                v  = ($urandom % 10) != 0;
                w  = 1'($urandom);
                wd = 1'($urandom);
                bus_chk(v, a, d, w, wd, model(v, a, d, w, wd), "R7 random vs model");
            end
        end

        bus_chk(0, 16'h0000, 16'h0000, 0, 0, 4'b0000, "R11 final idle");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule